// File: doc/BRIEF.md
# Dual-Clock Ingress Packet FIFO

This block carries ingress packet data from the processor clock domain into the switch path clock domain. A formatter pushes 32-bit words on the write clock. It flags the first word of each packet and gives the packet length in bytes with it. The switch-side consumer pops words on its own clock. The block marks the final 4-byte unit of each packet, so the consumer takes exactly as many units as the length calls for.

Storage is 64 words (256 bytes). This holds three full 80-byte packets with four words to spare. That margin lets the switch side insert one filler packet without any flow control on the link. A programmable threshold, counted in words, raises an almost-full flag on the write side. A mode bit chooses how that flag pushes back on the formatter. In one mode it drops the receive-enable handshake. In the other it withdraws the grant for the highest-priority shared-memory class. A write attempted while the store is full is dropped, and this sets a sticky overflow flag.

Top module: `pkt_ingress_fifo`

## Requirements
- R1: Words leave the read side in the order they were accepted on the write side, with their 32 data bits unchanged, although the two clocks are unrelated. While rd_valid is high and rd_ready is low, rd_data and rd_last hold steady.
- R2: The store holds 64 words. With the reader stalled, 64 writes are accepted, three 80-byte packets (60 words) fit without overflow, and further writes are dropped, so exactly 64 words are later read out.
- R3: overflow goes to 1 when a write is presented while the store is full. It stays 1 until the write-side reset, which clears it to 0.
- R4: A packet starts with wr_sop=1 and length L bytes on wr_len_bytes. Its last word is word number ceil(L/4) counting from 1, and a length of 0 counts as one word. rd_last is 1 on that word and 0 on the packet's other words.
- R5: almost_full equals 1 exactly when the write-side fill level in words is at or above cfg_af_thresh. It changes at the write-clock edge that accepts the write and clears once reads bring the level below the threshold.
- R6: With cfg_bp_mode=0, rx_enable equals the inverse of almost_full and prio0_grant stays 1.
- R7: With cfg_bp_mode=1, prio0_grant equals the inverse of almost_full and rx_enable stays 1.
- R8: After reset, rd_valid=0, almost_full=0 (for a nonzero threshold), overflow=0, rx_enable=1 and prio0_grant=1.
- R9: rd_valid is 0 when the store is empty. Asserting rd_ready while it is empty moves nothing, and the next written word still reads out correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Processor-side write clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_valid | input | 1 | Write strobe for wr_data |
| wr_sop | input | 1 | Marks the first word of a packet |
| wr_len_bytes | input | 7 | Packet length in bytes, sampled with wr_sop |
| wr_data | input | 32 | Write data word |
| cfg_af_thresh | input | 7 | Almost-full threshold in words (0 to 64) |
| cfg_bp_mode | input | 1 | 0: backpressure via rx_enable, 1: via prio0_grant |
| almost_full | output | 1 | Fill level at or above threshold |
| overflow | output | 1 | Sticky: a write arrived while full |
| rx_enable | output | 1 | Receive-enable handshake to the formatter |
| prio0_grant | output | 1 | Grant for the top-priority shared-memory class |
| rd_clk | input | 1 | Switch path read clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_ready | input | 1 | Consumer takes the current word |
| rd_valid | output | 1 | A word is available |
| rd_data | output | 32 | Read data word |
| rd_last | output | 1 | Current word is the last unit of its packet |

## Verification
The first pattern is a stalled reader filled to capacity and then pushed past it. It separates correct depth, full detection and dropping of extra writes from designs that lose or keep words beyond 64. The second pattern steps the level word by word across a threshold under each mode bit. It tells the two backpressure actions apart and shows exactly where the flag switches. The last pattern is a seeded random run with packets of random length, including 0, 1 and 80 bytes, under random reader stalls, with the writer obeying rx_enable. It checks ordering, end-of-packet marking and the absence of overflow when the handshake is honoured.

// File: rtl/pkt_fifo_pkg.sv
`timescale 1ns/1ps
package pkt_fifo_pkg;

    localparam int LEN_W          = 7;
    localparam int BYTES_PER_WORD = 4;
    localparam int GRAY_MAX_W     = 16;

    typedef enum logic {
        BP_RXEN  = 1'b0,
        BP_GRANT = 1'b1
    } bp_mode_e;

    function automatic logic [GRAY_MAX_W-1:0] to_gray(input logic [GRAY_MAX_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GRAY_MAX_W-1:0] from_gray(input logic [GRAY_MAX_W-1:0] g);
        logic [GRAY_MAX_W-1:0] b;
        b[GRAY_MAX_W-1] = g[GRAY_MAX_W-1];
        for (int i = GRAY_MAX_W-2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // Number of 4-byte units a packet of len bytes occupies; zero length is one unit.
    function automatic logic [LEN_W-1:0] units_of_len(input logic [LEN_W-1:0] len);
        logic [LEN_W:0] sum;
        sum = {1'b0, len} + (LEN_W+1)'(BYTES_PER_WORD - 1);
        if (len == '0) begin
            return LEN_W'(1);
        end
        return LEN_W'(sum / (LEN_W+1)'(BYTES_PER_WORD));
    endfunction

endpackage

// File: rtl/pkt_fifo_sync.sv
`timescale 1ns/1ps
module pkt_fifo_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/pkt_fifo_mem.sv
`timescale 1ns/1ps
module pkt_fifo_mem #(
    parameter int ENTRY_W = 33,
    parameter int ADDR_W  = 6
) (
    input  logic               wr_clk,
    input  logic               we,
    input  logic [ADDR_W-1:0]  waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [ADDR_W-1:0]  raddr,
    output logic [ENTRY_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [ENTRY_W-1:0] store_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];

endmodule

// File: rtl/pkt_fifo_wr.sv
`timescale 1ns/1ps
module pkt_fifo_wr
    import pkt_fifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_sop,
    input  logic [LEN_W-1:0]  wr_len_bytes,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W:0]   cfg_af_thresh,
    input  logic              cfg_bp_mode,
    input  logic [ADDR_W:0]   rptr_gray_sync,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W:0]   mem_wdata,
    output logic [ADDR_W:0]   wptr_gray,
    output logic              full,
    output logic              accept,
    output logic              almost_full,
    output logic              overflow,
    output logic              rx_enable,
    output logic              prio0_grant
);

    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] wgray;
        logic [LEN_W-1:0] left;
        logic             af;
        logic             ovf;
    } wr_state_t;

    wr_state_t st_d, st_q;

    logic [PTR_W-1:0] rptr_bin;
    logic [PTR_W-1:0] level_now;
    logic [PTR_W-1:0] level_next;
    logic [LEN_W-1:0] left_now;
    logic             is_last;

    always_comb begin
        st_d       = st_q;
        rptr_bin   = PTR_W'(from_gray(GRAY_MAX_W'(rptr_gray_sync)));
        level_now  = st_q.wptr - rptr_bin;
        full       = (level_now == PTR_W'(DEPTH));
        accept     = wr_valid && !full;

        if (wr_sop) begin
            left_now = units_of_len(wr_len_bytes) - LEN_W'(1);
        end else if (st_q.left == '0) begin
            left_now = '0;
        end else begin
            left_now = st_q.left - LEN_W'(1);
        end
        is_last = (left_now == '0);

        if (accept) begin
            st_d.wptr  = st_q.wptr + PTR_W'(1);
            st_d.left  = left_now;
        end
        st_d.wgray = PTR_W'(to_gray(GRAY_MAX_W'(st_d.wptr)));
        if (wr_valid && full) begin
            st_d.ovf = 1'b1;
        end

        level_next = st_d.wptr - rptr_bin;
        st_d.af    = (level_next >= cfg_af_thresh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we      = accept;
    assign mem_waddr   = st_q.wptr[ADDR_W-1:0];
    assign mem_wdata   = {is_last, wr_data};
    assign wptr_gray   = st_q.wgray;
    assign almost_full = st_q.af;
    assign overflow    = st_q.ovf;
    assign rx_enable   = (bp_mode_e'(cfg_bp_mode) == BP_RXEN)  ? !st_q.af : 1'b1;
    assign prio0_grant = (bp_mode_e'(cfg_bp_mode) == BP_GRANT) ? !st_q.af : 1'b1;

endmodule

// File: rtl/pkt_fifo_rd.sv
`timescale 1ns/1ps
module pkt_fifo_rd
    import pkt_fifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_ready,
    input  logic [ADDR_W:0]   wptr_gray_sync,
    input  logic [DATA_W:0]   mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [ADDR_W:0]   rptr_gray,
    output logic [ADDR_W:0]   rptr_bin,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last
);

    localparam int PTR_W = ADDR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] rptr;
        logic [PTR_W-1:0] rgray;
    } rd_state_t;

    rd_state_t st_d, st_q;

    logic [PTR_W-1:0] wptr_bin;
    logic             pop;

    always_comb begin
        st_d     = st_q;
        wptr_bin = PTR_W'(from_gray(GRAY_MAX_W'(wptr_gray_sync)));
        rd_valid = (st_q.rptr != wptr_bin);
        pop      = rd_valid && rd_ready;
        if (pop) begin
            st_d.rptr = st_q.rptr + PTR_W'(1);
        end
        st_d.rgray = PTR_W'(to_gray(GRAY_MAX_W'(st_d.rptr)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_raddr = st_q.rptr[ADDR_W-1:0];
    assign rptr_gray = st_q.rgray;
    assign rptr_bin  = st_q.rptr;
    assign rd_data   = mem_rdata[DATA_W-1:0];
    assign rd_last   = mem_rdata[DATA_W];

endmodule

// File: rtl/pkt_ingress_fifo.sv
`timescale 1ns/1ps
module pkt_ingress_fifo
    import pkt_fifo_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_valid,
    input  logic              wr_sop,
    input  logic [6:0]        wr_len_bytes,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W:0]   cfg_af_thresh,
    input  logic              cfg_bp_mode,
    output logic              almost_full,
    output logic              overflow,
    output logic              rx_enable,
    output logic              prio0_grant,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last
);

    localparam int PTR_W   = ADDR_W + 1;
    localparam int ENTRY_W = DATA_W + 1;

    logic               mem_we;
    logic [ADDR_W-1:0]  mem_waddr;
    logic [ENTRY_W-1:0] mem_wdata;
    logic [ADDR_W-1:0]  mem_raddr;
    logic [ENTRY_W-1:0] mem_rdata;
    logic [PTR_W-1:0]   wptr_gray, wptr_gray_rs;
    logic [PTR_W-1:0]   rptr_gray, rptr_gray_ws;
    logic [PTR_W-1:0]   rd_ptr;
    logic               wr_full;
    logic               wr_accept;

    pkt_fifo_wr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr (
        .clk            (wr_clk),
        .rst_n          (wr_rst_n),
        .wr_valid       (wr_valid),
        .wr_sop         (wr_sop),
        .wr_len_bytes   (wr_len_bytes),
        .wr_data        (wr_data),
        .cfg_af_thresh  (cfg_af_thresh),
        .cfg_bp_mode    (cfg_bp_mode),
        .rptr_gray_sync (rptr_gray_ws),
        .mem_we         (mem_we),
        .mem_waddr      (mem_waddr),
        .mem_wdata      (mem_wdata),
        .wptr_gray      (wptr_gray),
        .full           (wr_full),
        .accept         (wr_accept),
        .almost_full    (almost_full),
        .overflow       (overflow),
        .rx_enable      (rx_enable),
        .prio0_grant    (prio0_grant)
    );

    pkt_fifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk      (wr_clk),
        .rst_n    (wr_rst_n),
        .async_in (rptr_gray),
        .sync_out (rptr_gray_ws)
    );

    pkt_fifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk      (rd_clk),
        .rst_n    (rd_rst_n),
        .async_in (wptr_gray),
        .sync_out (wptr_gray_rs)
    );

    pkt_fifo_mem #(.ENTRY_W(ENTRY_W), .ADDR_W(ADDR_W)) u_mem (
        .wr_clk (wr_clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (mem_wdata),
        .raddr  (mem_raddr),
        .rdata  (mem_rdata)
    );

    pkt_fifo_rd #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk            (rd_clk),
        .rst_n          (rd_rst_n),
        .rd_ready       (rd_ready),
        .wptr_gray_sync (wptr_gray_rs),
        .mem_rdata      (mem_rdata),
        .mem_raddr      (mem_raddr),
        .rptr_gray      (rptr_gray),
        .rptr_bin       (rd_ptr),
        .rd_valid       (rd_valid),
        .rd_data        (rd_data),
        .rd_last        (rd_last)
    );

endmodule

// File: rtl/pkt_fifo_chk.sv
`timescale 1ns/1ps
module pkt_fifo_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              wr_valid,
    input logic              wr_full,
    input logic              overflow,
    input logic              almost_full,
    input logic              rx_enable,
    input logic              prio0_grant,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_last,
    input logic [ADDR_W:0]   rd_ptr
);

    // R3
    overflow_sticky_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        overflow |=> overflow);

    // R3
    overflow_cause_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $rose(overflow) |-> $past(wr_valid && wr_full));

    // R6 R7
    no_pressure_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !almost_full |-> (rx_enable && prio0_grant));

    // R6 R7
    one_action_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        almost_full |-> (rx_enable ^ prio0_grant));

    // R1
    read_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));

    // R9
    empty_idle_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_valid |=> $stable(rd_ptr));

endmodule

bind pkt_ingress_fifo pkt_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .wr_clk      (wr_clk),
    .wr_rst_n    (wr_rst_n),
    .rd_clk      (rd_clk),
    .rd_rst_n    (rd_rst_n),
    .wr_valid    (wr_valid),
    .wr_full     (wr_full),
    .overflow    (overflow),
    .almost_full (almost_full),
    .rx_enable   (rx_enable),
    .prio0_grant (prio0_grant),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .rd_data     (rd_data),
    .rd_last     (rd_last),
    .rd_ptr      (rd_ptr)
);

// File: tb/pkt_ingress_fifo_tb.sv
`timescale 1ns/1ps
module pkt_ingress_fifo_tb;

    logic        wr_clk = 0, rd_clk = 0;
    logic        wr_rst_n = 0, rd_rst_n = 0;
    logic        wr_valid = 0, wr_sop = 0;
    logic [6:0]  wr_len_bytes = 0;
    logic [31:0] wr_data = 0;
    logic [6:0]  cfg_af_thresh = 7'd64;
    logic        cfg_bp_mode = 0;
    logic        almost_full, overflow, rx_enable, prio0_grant;
    logic        rd_ready = 0;
    logic        rd_valid, rd_last;
    logic [31:0] rd_data;

    int errors = 0, checks = 0, rx_count = 0, rd_pct = 100;
    bit rd_go = 0, done = 0;
    logic [32:0] exp_q[$];

    always #2.5 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    pkt_ingress_fifo u_dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_sop(wr_sop),
        .wr_len_bytes(wr_len_bytes), .wr_data(wr_data), .cfg_af_thresh(cfg_af_thresh),
        .cfg_bp_mode(cfg_bp_mode), .almost_full(almost_full), .overflow(overflow),
        .rx_enable(rx_enable), .prio0_grant(prio0_grant), .rd_clk(rd_clk),
        .rd_rst_n(rd_rst_n), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_last(rd_last)
    );

    function automatic int units_for(input int len);
        return (len == 0) ? 1 : (len + 3) / 4;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Reader: decides rd_ready at each read-clock falling edge and scores the word it takes.
    always @(negedge rd_clk) begin
        bit take;
        logic [32:0] e;
        if (rd_go) begin
            take = (($urandom % 100) < rd_pct);
            rd_ready = take;
            if (take && rd_valid) begin
                rx_count++;
                if (exp_q.size() == 0) begin
                    chk(0, "R1 unexpected word", int'(rd_data), 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(rd_data == e[31:0], "R1 data", int'(rd_data), int'(e[31:0]));
                    chk(rd_last == e[32], "R4 last", int'(rd_last), int'(e[32]));
                end
            end
        end else begin
            rd_ready = 0;
        end
    end

    // Called at a write-clock falling edge; returns at the next falling edge.
    task automatic put_word(input logic [31:0] d, input bit s, input int len);
        wr_valid = 1; wr_data = d; wr_sop = s; wr_len_bytes = 7'(len);
        @(negedge wr_clk);
        wr_valid = 0; wr_sop = 0;
    endtask

    task automatic send_pkt(input int len, input bit obey, input bit expect_it);
        int n;
        logic [31:0] d;
        n = units_for(len);
        for (int i = 0; i < n; i++) begin
            if (obey) while (!rx_enable) @(negedge wr_clk);
            d = $urandom;
            put_word(d, i == 0, len);
            if (expect_it) exp_q.push_back({(i == n-1), d});
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 20000 && exp_q.size() != 0; i++) @(negedge rd_clk);
        repeat (20) @(negedge rd_clk);
        @(negedge wr_clk);
    endtask

    task automatic do_reset();
        rd_go = 0;
        @(negedge wr_clk);
        wr_rst_n = 0; rd_rst_n = 0;
        exp_q.delete();
        repeat (5) @(negedge wr_clk);
        wr_rst_n = 1; rd_rst_n = 1;
        repeat (3) @(negedge wr_clk);
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        chk(0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        int n;
        void'($urandom(32'h5EED_1234));
        do_reset();

        // R8: reset state
        chk(rd_valid == 0, "R8 rd_valid", rd_valid, 0);
        chk(almost_full == 0, "R8 almost_full", almost_full, 0);
        chk(overflow == 0, "R8 overflow", overflow, 0);
        chk(rx_enable == 1 && prio0_grant == 1, "R8 rx_enable/prio0_grant",
            {rx_enable, prio0_grant}, 3);

        // R2 R5 R6: stalled reader, three 80-byte packets then fill and overrun
        cfg_bp_mode = 0; cfg_af_thresh = 7'd60;
        @(negedge wr_clk);
        n = 0;
        for (int p = 0; p < 3; p++) begin
            for (int w = 0; w < 20; w++) begin
                logic [31:0] d;
                d = $urandom;
                put_word(d, w == 0, 80);
                exp_q.push_back({(w == 19), d});
                n++;
                chk(almost_full == (n >= 60), "R5 flag vs level", almost_full, n >= 60);
                chk(rx_enable == !(n >= 60) && prio0_grant, "R6 mode0 outputs",
                    {rx_enable, prio0_grant}, {!(n >= 60), 1'b1});
            end
        end
        chk(overflow == 0, "R2 three packets fit", overflow, 0);
        for (int k = 0; k < 4; k++) send_pkt(4, 0, 1);
        chk(overflow == 0, "R2 64 words fit", overflow, 0);
        for (int k = 0; k < 3; k++) send_pkt(8, 0, 0);
        chk(overflow == 1, "R3 overflow set", overflow, 1);
        rx_count = 0; rd_pct = 100; rd_go = 1;
        drain();
        chk(rx_count == 64, "R2 words read out", rx_count, 64);
        chk(rd_valid == 0, "R9 empty after drain", rd_valid, 0);
        repeat (10) @(negedge wr_clk);
        chk(almost_full == 0, "R5 clears below threshold", almost_full, 0);
        chk(overflow == 1, "R3 overflow sticky", overflow, 1);

        // R9: ready held high while empty, then one word
        rd_go = 1; rd_pct = 100;
        repeat (30) @(negedge rd_clk);
        @(negedge wr_clk);
        chk(rd_valid == 0, "R9 idle while empty", rd_valid, 0);
        rx_count = 0;
        send_pkt(3, 0, 1);
        drain();
        chk(rx_count == 1, "R9 single word after idle", rx_count, 1);

        // R7: grant mode, threshold 5
        rd_go = 0; cfg_bp_mode = 1; cfg_af_thresh = 7'd5;
        repeat (5) @(negedge wr_clk);
        for (int k = 1; k <= 6; k++) begin
            send_pkt(4, 0, 1);
            chk(almost_full == (k >= 5), "R5 flag vs level", almost_full, k >= 5);
            chk(prio0_grant == !(k >= 5) && rx_enable, "R7 mode1 outputs",
                {prio0_grant, rx_enable}, {!(k >= 5), 1'b1});
        end
        rd_go = 1; rd_pct = 100;
        drain();
        repeat (10) @(negedge wr_clk);
        chk(prio0_grant == 1 && almost_full == 0, "R7 grant restored",
            {prio0_grant, almost_full}, 2);

        // R3: reset clears the sticky flag
        do_reset();
        chk(overflow == 0, "R3 cleared by reset", overflow, 0);

        // R4: directed length corners with a half-rate reader
        cfg_bp_mode = 0; cfg_af_thresh = 7'd48; rd_go = 1; rd_pct = 50;
        send_pkt(0, 1, 1); send_pkt(1, 1, 1); send_pkt(3, 1, 1); send_pkt(4, 1, 1);
        send_pkt(5, 1, 1); send_pkt(77, 1, 1); send_pkt(80, 1, 1);
        drain();
        chk(exp_q.size() == 0, "R4 corner packets delivered", exp_q.size(), 0);

        // R1 R6: random packets, writer honours rx_enable, reader stalls at random
        rd_pct = 60;
        for (int p = 0; p < 60; p++) begin
            int gap;
            send_pkt($urandom % 81, 1, 1);
            gap = $urandom % 3;
            repeat (gap) @(negedge wr_clk);
        end
        drain();
        chk(exp_q.size() == 0, "R1 all random words delivered", exp_q.size(), 0);
        chk(overflow == 0, "R6 handshake prevents overflow", overflow, 0);

        summary();
    end

endmodule